// File: doc/BRIEF.md
# Coprocessor Escape Snoop and Operand Mover

This block sits beside a host CPU on its 16-bit multiplexed address/data bus. It keeps a byte-wide mirror of the host's instruction prefetch queue. The mirror fills from the host's code fetch cycles and drains under the host's two queue status lines, so the block sees each instruction byte when the host takes it. A first byte whose top five bits are `11011` marks a coprocessor (escape) instruction. The block then joins its low three bits with the byte that follows to form an 11-bit coprocessor opcode. Every other opcode passes by untouched.

For an escape with a memory operand, the block moves the operand itself. The host runs one operand read cycle, and the block latches its address. For an operand load, the data word of that host cycle becomes the first operand word. Any further words are fetched by DMA at the following even addresses. For an operand store, the host's data word is dropped, and all words are written by DMA starting at the latched address. Results leave on two valid/ready streams: the opcode stream and the read operand stream. Words to be stored arrive on a third valid/ready stream. A `busy_o` level lets the host poll before it issues its next escape.

Stream rules: a source raises valid and holds it, with data stable, until the cycle in which ready is also high. The opcode stays on `op_code_o` until it is accepted. Read words wait in an internal buffer that is deep enough for the longest operand, so `rd_ready_i` may stay low for as long as needed. A store waits in DMA request, with no bus cycle, until a store word is valid. `wr_ready_o` is high only in the data phase of a store. The environment holds `dma_gnt_i` until the request drops, and the host waits for `busy_o` low before taking its next escape byte.

Top module: `cop_escape_snoop`

## Requirements
- R1: A byte taken with queue status 01 (first opcode byte) whose bits [7:3] equal 11011 starts a decode, and `busy_o` is high in the cycle after. Any other first byte leaves `busy_o` low and yields no opcode.
- R2: The coprocessor opcode is {escape byte bits [2:0], next byte [7:0]}, taken when queue status 11 (subsequent byte) removes the second byte. `op_valid_o` and `op_code_o` stay unchanged until `op_ready_i` accepts them.
- R3: A host code fetch (address strobe with `bus_fetch_i` high, then `bus_rd_i`) appends the low byte and then the high byte to the mirror. Queue status 01 or 11 removes the oldest byte, 10 empties the mirror, and 00 leaves it unchanged.
- R4: For an operand load, the data word on the bus during the host's operand read becomes the first word on the read stream. A one-word load causes no DMA request.
- R5: For a load of N>1 words, after the host's read the block requests DMA and reads addresses A+2 through A+2(N-1), where A is the host's operand address. Words appear on the read stream in address order.
- R6: For an operand store, the host's data word never reaches the read stream. The block writes N words from the store stream to addresses A, A+2, and so on, in stream order.
- R7: The bus outputs (`bus_oe_o` and the strobes) are active only while `dma_gnt_i` is high. `dma_req_o` falls in the cycle after the final data phase. Exactly one request occurs per transfer.
- R8: `busy_o` stays high from escape decode until the operand transfer is finished and the opcode has been accepted. It is high whenever `dma_req_o` is high.
- R9: A memory-form escape whose {escape bits [2:0], second byte bits [5:3]} is not in the supported set raises `err_o`. It produces no opcode and no DMA request. `err_o` clears when the next escape first byte is taken. The supported set is: 001/000 load 2 words, 001/010 store 2 words, 101/000 load 4, 101/010 store 4, 011/101 load 5, 011/111 store 5, 111/000 load 1, 111/010 store 1.
- R10: A register form (second byte bits [7:6] = 11) produces an opcode and no bus activity.
- R11: Read words held back by a low `rd_ready_i` are neither lost nor reordered.
- R12: A store waits in DMA request, with no address phase, until a store word is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ad_i | input | 16 | Multiplexed address/data seen on the host bus |
| bus_ale_i | input | 1 | Host address phase strobe |
| bus_fetch_i | input | 1 | Host cycle is a code fetch (valid with `bus_ale_i`) |
| bus_rd_i | input | 1 | Host read data phase |
| qs_i | input | 2 | Host queue status: 00 none, 01 first byte, 10 flush, 11 next byte |
| dma_gnt_i | input | 1 | Bus grant |
| dma_req_o | output | 1 | Bus request |
| bus_ad_o | output | 16 | Address/data driven during DMA |
| bus_oe_o | output | 1 | Enable for `bus_ad_o` |
| bus_ale_o | output | 1 | DMA address phase |
| bus_rd_o | output | 1 | DMA read data phase |
| bus_wr_o | output | 1 | DMA write data phase |
| op_valid_o | output | 1 | Opcode stream valid |
| op_ready_i | input | 1 | Opcode stream ready |
| op_code_o | output | 11 | Coprocessor opcode |
| rd_valid_o | output | 1 | Read operand stream valid |
| rd_ready_i | input | 1 | Read operand stream ready |
| rd_data_o | output | 16 | Read operand word |
| wr_valid_i | input | 1 | Store stream valid |
| wr_ready_o | output | 1 | Store stream ready |
| wr_data_i | input | 16 | Store word |
| busy_o | output | 1 | Escape in progress |
| err_o | output | 1 | Last escape was an unsupported memory form |

## Verification
A wrong byte count in the mirror shows up at the next decode: a later escape is missed or decoded from the wrong byte, or a plain opcode raises `busy_o` one cycle after its queue-status strobe. An address or word-count error in the DMA sequencer shows up within one address/data phase pair as a wrong address, a word out of order on the read or store stream, or a request that outlives the final data phase. Each of these is compared against a queue of expected items filled from the stimulus.

// File: rtl/cop_snoop_pkg.sv
package cop_snoop_pkg;

  localparam int DW = 16;
  localparam int BW = 8;
  localparam int OP_W = 3 + BW;
  localparam int LEN_W = 3;
  localparam logic [4:0] ESC_TAG = 5'b11011;

  typedef enum logic [1:0] {
    QS_NONE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qstat_e;

  typedef enum logic [2:0] {
    S_IDLE, S_MODRM, S_WAIT_ALE, S_WAIT_DATA, S_XFER
  } dec_state_e;

  typedef struct packed {
    logic             ok;
    logic             wr;
    logic [LEN_W-1:0] words;
  } mem_form_t;

  // Memory-form lookup keyed by escape low bits and the selector field.
  function automatic mem_form_t classify(input logic [2:0] esc, input logic [2:0] sel);
    mem_form_t r;
    r.ok = 1'b1;
    r.wr = 1'b0;
    r.words = '0;
    case ({esc, sel})
      6'b001_000: r.words = 3'd2;
      6'b001_010: begin r.words = 3'd2; r.wr = 1'b1; end
      6'b101_000: r.words = 3'd4;
      6'b101_010: begin r.words = 3'd4; r.wr = 1'b1; end
      6'b011_101: r.words = 3'd5;
      6'b011_111: begin r.words = 3'd5; r.wr = 1'b1; end
      6'b111_000: r.words = 3'd1;
      6'b111_010: begin r.words = 3'd1; r.wr = 1'b1; end
      default:    r.ok = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cop_prefetch_mirror.sv
module cop_prefetch_mirror #(
  parameter int DEPTH = 6,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale_i,
  input  logic            fetch_i,
  input  logic            rd_i,
  input  logic [2*BW-1:0] word_i,
  input  logic            pop_i,
  input  logic            flush_i,
  output logic [BW-1:0]   head_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [BW-1:0] q  [DEPTH];
  logic [BW-1:0] sh [DEPTH];
  logic [BW-1:0] nq [DEPTH];
  logic [CW-1:0] cnt, base, ncnt;
  logic          code_cyc, push, pop_eff;

  // Remember whether the current host cycle is a code fetch.
  always_ff @(posedge clk) begin
    if (!rst_n)     code_cyc <= 1'b0;
    else if (ale_i) code_cyc <= fetch_i;
    else if (rd_i)  code_cyc <= 1'b0;
  end

  assign push    = rd_i && code_cyc;
  assign pop_eff = pop_i && (cnt != '0);
  assign base    = cnt - CW'(pop_eff);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    if (g < DEPTH - 1) begin : g_mid
      assign sh[g] = pop_eff ? q[g+1] : q[g];
    end else begin : g_last
      assign sh[g] = pop_eff ? '0 : q[g];
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      nq[i] = sh[i];
      if (push && CW'(i) == base)         nq[i] = word_i[BW-1:0];
      if (push && CW'(i) == base + CW'(1)) nq[i] = word_i[2*BW-1:BW];
    end
    ncnt = base + (push ? CW'(2) : CW'(0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else if (flush_i) begin
      cnt <= '0;
    end else begin
      cnt <= ncnt;
      q   <= nq;
    end
  end

  assign head_o = q[0];

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush_i) |-> (32'(base) + 2 <= DEPTH))
    else $error("mirror overflow");

  p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !flush_i) |-> (cnt != '0))
    else $error("byte taken from empty mirror");

endmodule

// File: rtl/cop_operand_fifo.sv
module cop_operand_fifo #(
  parameter int W = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          pop;

  assign valid_o = (cnt != '0);
  assign pop     = valid_o && ready_i;
  assign data_o  = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
    end else begin
      if (push_i) begin
        mem[wp] <= data_i;
        wp <= nxt(wp);
      end
      if (pop) rp <= nxt(rp);
      cnt <= cnt + CW'(push_i) - CW'(pop);
    end
  end

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt != CW'(DEPTH)) || pop)
    else $error("operand buffer overflow");

endmodule

// File: rtl/cop_dma_mover.sv
module cop_dma_mover #(
  parameter int W = 16,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wr_dir_i,
  input  logic [W-1:0]     base_i,
  input  logic [LEN_W-1:0] words_i,
  input  logic             dma_gnt_i,
  output logic             dma_req_o,
  input  logic [W-1:0]     bus_ad_i,
  output logic [W-1:0]     bus_ad_o,
  output logic             bus_oe_o,
  output logic             bus_ale_o,
  output logic             bus_rd_o,
  output logic             bus_wr_o,
  output logic             rdw_push_o,
  output logic [W-1:0]     rdw_data_o,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  input  logic [W-1:0]     wr_data_i,
  output logic             done_o
);
  typedef enum logic [1:0] {M_IDLE, M_REQ, M_ADDR, M_DATA} mv_state_e;

  mv_state_e        st;
  logic [W-1:0]     addr;
  logic [LEN_W-1:0] left;
  logic             dir_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= M_IDLE;
      addr <= '0;
      left <= '0;
      dir_wr <= 1'b0;
    end else begin
      case (st)
        M_IDLE: if (start_i) begin
          st <= M_REQ;
          addr <= base_i;
          left <= words_i;
          dir_wr <= wr_dir_i;
        end
        M_REQ:  if (dma_gnt_i && (!dir_wr || wr_valid_i)) st <= M_ADDR;
        M_ADDR: st <= M_DATA;
        M_DATA: begin
          addr <= addr + W'(2);
          left <= left - LEN_W'(1);
          st <= (left == LEN_W'(1)) ? M_IDLE : M_REQ;
        end
        default: st <= M_IDLE;
      endcase
    end
  end

  assign dma_req_o  = (st != M_IDLE);
  assign bus_ale_o  = (st == M_ADDR) && dma_gnt_i;
  assign bus_rd_o   = (st == M_DATA) && !dir_wr && dma_gnt_i;
  assign bus_wr_o   = (st == M_DATA) && dir_wr && dma_gnt_i;
  assign bus_oe_o   = bus_ale_o || bus_wr_o;
  assign bus_ad_o   = bus_wr_o ? wr_data_i : addr;
  assign wr_ready_o = bus_wr_o;
  assign rdw_push_o = bus_rd_o;
  assign rdw_data_o = bus_ad_i;
  assign done_o     = (st == M_DATA) && (left == LEN_W'(1));

  p_gnt_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_ADDR || st == M_DATA) |-> dma_gnt_i)
    else $error("grant withdrawn during a transfer");

  p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_req_o) |-> $past(bus_rd_o || bus_wr_o))
    else $error("request dropped outside a data phase");

  p_wr_word_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready_o |-> wr_valid_i)
    else $error("store data phase without a word");

endmodule

// File: rtl/cop_escape_snoop.sv
module cop_escape_snoop
  import cop_snoop_pkg::*;
#(
  parameter int QDEPTH = 6,
  parameter int OPBUF_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   bus_ad_i,
  input  logic            bus_ale_i,
  input  logic            bus_fetch_i,
  input  logic            bus_rd_i,
  input  logic [1:0]      qs_i,
  input  logic            dma_gnt_i,
  output logic            dma_req_o,
  output logic [DW-1:0]   bus_ad_o,
  output logic            bus_oe_o,
  output logic            bus_ale_o,
  output logic            bus_rd_o,
  output logic            bus_wr_o,
  output logic            op_valid_o,
  input  logic            op_ready_i,
  output logic [OP_W-1:0] op_code_o,
  output logic            rd_valid_o,
  input  logic            rd_ready_i,
  output logic [DW-1:0]   rd_data_o,
  input  logic            wr_valid_i,
  output logic            wr_ready_o,
  input  logic [DW-1:0]   wr_data_i,
  output logic            busy_o,
  output logic            err_o
);
  dec_state_e       st;
  logic [2:0]       esc_lo;
  logic [DW-1:0]    opnd_addr;
  logic             f_wr;
  logic [LEN_W-1:0] f_words;
  logic [BW-1:0]    head;
  logic             qs_first, qs_next, flush, is_esc, host_data;
  mem_form_t        cls;
  logic             mv_start, mv_push, mv_done, buf_push;
  logic [DW-1:0]    mv_data, buf_data, mv_base;
  logic [LEN_W-1:0] mv_words;

  assign qs_first  = (qs_i == QS_FIRST);
  assign qs_next   = (qs_i == QS_NEXT);
  assign flush     = (qs_i == QS_FLUSH);
  assign is_esc    = (head[7:3] == ESC_TAG);
  assign cls       = classify(esc_lo, head[5:3]);
  assign host_data = (st == S_WAIT_DATA) && bus_rd_i;

  cop_prefetch_mirror #(.DEPTH(QDEPTH), .BW(BW)) u_mirror (
    .clk(clk), .rst_n(rst_n),
    .ale_i(bus_ale_i), .fetch_i(bus_fetch_i), .rd_i(bus_rd_i),
    .word_i(bus_ad_i), .pop_i(qs_first || qs_next), .flush_i(flush),
    .head_o(head)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      esc_lo <= '0;
      opnd_addr <= '0;
      f_wr <= 1'b0;
      f_words <= '0;
      op_valid_o <= 1'b0;
      op_code_o <= '0;
      err_o <= 1'b0;
    end else begin
      if (op_valid_o && op_ready_i) op_valid_o <= 1'b0;
      case (st)
        S_IDLE: if (qs_first && is_esc) begin
          esc_lo <= head[2:0];
          err_o <= 1'b0;
          st <= S_MODRM;
        end
        S_MODRM: if (qs_next) begin
          if (head[7:6] == 2'b11) begin
            op_code_o <= {esc_lo, head};
            op_valid_o <= 1'b1;
            st <= S_IDLE;
          end else if (cls.ok) begin
            op_code_o <= {esc_lo, head};
            op_valid_o <= 1'b1;
            f_wr <= cls.wr;
            f_words <= cls.words;
            st <= S_WAIT_ALE;
          end else begin
            err_o <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_WAIT_ALE: if (bus_ale_i && !bus_fetch_i) begin
          opnd_addr <= bus_ad_i;
          st <= S_WAIT_DATA;
        end
        S_WAIT_DATA: if (bus_rd_i) st <= mv_start ? S_XFER : S_IDLE;
        S_XFER: if (mv_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mv_start = host_data && (f_wr || f_words != LEN_W'(1));
  assign mv_base  = f_wr ? opnd_addr : opnd_addr + DW'(2);
  assign mv_words = f_wr ? f_words : f_words - LEN_W'(1);

  cop_dma_mover #(.W(DW), .LEN_W(LEN_W)) u_mover (
    .clk(clk), .rst_n(rst_n),
    .start_i(mv_start), .wr_dir_i(f_wr), .base_i(mv_base), .words_i(mv_words),
    .dma_gnt_i(dma_gnt_i), .dma_req_o(dma_req_o),
    .bus_ad_i(bus_ad_i), .bus_ad_o(bus_ad_o), .bus_oe_o(bus_oe_o),
    .bus_ale_o(bus_ale_o), .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o),
    .rdw_push_o(mv_push), .rdw_data_o(mv_data),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_data_i(wr_data_i),
    .done_o(mv_done)
  );

  assign buf_push = (host_data && !f_wr) || mv_push;
  assign buf_data = mv_push ? mv_data : bus_ad_i;

  cop_operand_fifo #(.W(DW), .DEPTH(OPBUF_DEPTH)) u_rdbuf (
    .clk(clk), .rst_n(rst_n),
    .push_i(buf_push), .data_i(buf_data),
    .valid_o(rd_valid_o), .ready_i(rd_ready_i), .data_o(rd_data_o)
  );

  assign busy_o = (st != S_IDLE) || op_valid_o;

  p_plain_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && qs_first && !is_esc && !op_valid_o) |=> !busy_o)
    else $error("non-escape byte started a decode");

  p_op_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_o && !op_ready_i) |=> (op_valid_o && $stable(op_code_o)))
    else $error("opcode changed before acceptance");

  p_busy_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_o |-> busy_o)
    else $error("request while not busy");

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !dma_req_o)
    else $error("bus request after unsupported escape");

  p_one_push_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_data && mv_push))
    else $error("two writers into the operand buffer");

endmodule

// File: tb/cop_escape_snoop_bench.sv
module cop_escape_snoop_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [15:0] host_ad = '0;
  logic        bus_ale_i = 0, bus_fetch_i = 0, bus_rd_i = 0;
  logic [1:0]  qs_i = 2'b00;
  logic        dma_gnt_i = 0, op_ready_i = 1, rd_ready_i = 1, wr_valid_i = 0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] bus_ad_i, bus_ad_o, rd_data_o;
  logic        dma_req_o, bus_oe_o, bus_ale_o, bus_rd_o, bus_wr_o;
  logic        op_valid_o, rd_valid_o, wr_ready_o, busy_o, err_o;
  logic [10:0] op_code_o;

  logic [15:0] mem_addr = '0;
  assign bus_ad_i = bus_rd_o ? (mem_addr ^ 16'hA5C3) : host_ad;

  cop_escape_snoop u_cop_escape_snoop (
    .clk(clk), .rst_n(rst_n), .bus_ad_i(bus_ad_i), .bus_ale_i(bus_ale_i),
    .bus_fetch_i(bus_fetch_i), .bus_rd_i(bus_rd_i), .qs_i(qs_i),
    .dma_gnt_i(dma_gnt_i), .dma_req_o(dma_req_o), .bus_ad_o(bus_ad_o),
    .bus_oe_o(bus_oe_o), .bus_ale_o(bus_ale_o), .bus_rd_o(bus_rd_o),
    .bus_wr_o(bus_wr_o), .op_valid_o(op_valid_o), .op_ready_i(op_ready_i),
    .op_code_o(op_code_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
    .rd_data_o(rd_data_o), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
    .wr_data_i(wr_data_i), .busy_o(busy_o), .err_o(err_o)
  );

  int compared = 0, mismatched = 0;
  logic [10:0] exp_op[$];
  logic [15:0] exp_rd[$];
  logic [31:0] exp_wr[$];
  logic [15:0] wr_src[$];
  bit   wr_src_en = 1, wr_hs = 0;
  int   req_starts = 0, ale_count = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Grant follows the request; store source feeds the write stream.
  initial forever begin
    @(posedge clk);
    #1;
    dma_gnt_i = dma_req_o;
    if (wr_hs) void'(wr_src.pop_front());
    wr_valid_i = wr_src_en && (wr_src.size() > 0);
    wr_data_i  = (wr_src.size() > 0) ? wr_src[0] : 16'h0;
  end

  // Monitor / scoreboard.
  initial begin
    logic prev_req, prev_data;
    logic [15:0] wa;
    prev_req = 0; prev_data = 0; wa = '0;
    forever begin
      @(negedge clk);
      wr_hs = wr_valid_i && wr_ready_o;
      if (rst_n) begin
        if (op_valid_o && op_ready_i) begin
          if (exp_op.size() == 0) chk(0, "R2", {21'd0, op_code_o}, 32'h0);
          else begin
            logic [10:0] e;
            e = exp_op.pop_front();
            chk(op_code_o == e, "R2", {21'd0, op_code_o}, {21'd0, e});
          end
        end
        if (rd_valid_o && rd_ready_i) begin
          if (exp_rd.size() == 0) chk(0, "R4", {16'd0, rd_data_o}, 32'h0);
          else begin
            logic [15:0] e;
            e = exp_rd.pop_front();
            chk(rd_data_o == e, "R5", {16'd0, rd_data_o}, {16'd0, e});
          end
        end
        if (bus_ale_o) begin
          mem_addr = bus_ad_o;
          wa = bus_ad_o;
          ale_count++;
        end
        if (bus_wr_o) begin
          if (exp_wr.size() == 0) chk(0, "R6", {wa, bus_ad_o}, 32'h0);
          else begin
            logic [31:0] e;
            e = exp_wr.pop_front();
            chk({wa, bus_ad_o} == e, "R6", {wa, bus_ad_o}, e);
          end
        end
        if ((bus_oe_o || bus_ale_o || bus_rd_o || bus_wr_o) && !dma_gnt_i)
          chk(0, "R7", 32'(bus_oe_o), 32'h0);
        if (prev_req && !dma_req_o) chk(prev_data, "R7", 32'(prev_data), 32'h1);
        if (!prev_req && dma_req_o) req_starts++;
        if (dma_req_o && !busy_o) chk(0, "R8", 32'(busy_o), 32'h1);
        prev_req = dma_req_o;
        prev_data = bus_rd_o || bus_wr_o;
      end
    end
  end

  task automatic host_fetch(input logic [15:0] w);
    bus_ale_i = 1; bus_fetch_i = 1; host_ad = 16'h0400;
    step();
    bus_ale_i = 0; bus_rd_i = 1; host_ad = w;
    step();
    bus_rd_i = 0; bus_fetch_i = 0; host_ad = '0;
  endtask

  task automatic host_qs(input logic [1:0] c);
    qs_i = c;
    step();
    qs_i = 2'b00;
  endtask

  task automatic host_opread(input logic [15:0] a, input logic [15:0] d);
    bus_ale_i = 1; bus_fetch_i = 0; host_ad = a;
    step();
    bus_ale_i = 0; bus_rd_i = 1; host_ad = d;
    step();
    bus_rd_i = 0; host_ad = '0;
  endtask

  task automatic issue_esc(input logic [7:0] esc, input logic [7:0] modrm, input bit wr,
                           input int n, input logic [15:0] a, input logic [15:0] hd, input bit ok);
    bit mem;
    mem = (modrm[7:6] != 2'b11);
    if (ok) exp_op.push_back({esc[2:0], modrm});
    if (ok && mem && !wr) begin
      exp_rd.push_back(hd);
      for (int k = 1; k < n; k++) exp_rd.push_back((a + 16'(2 * k)) ^ 16'hA5C3);
    end
    if (ok && mem && wr) begin
      for (int k = 0; k < n; k++) begin
        logic [15:0] w;
        w = (a ^ 16'h0F0F) + 16'(k * 16'h0111);
        wr_src.push_back(w);
        exp_wr.push_back({a + 16'(2 * k), w});
      end
    end
    host_fetch({modrm, esc});
    host_qs(2'b01);
    chk(busy_o == 1'b1, "R1", 32'(busy_o), 32'h1);
    host_qs(2'b11);
    if (mem) host_opread(a, hd);
  endtask

  task automatic finish_esc(input int exp_reqs, input int base_reqs);
    for (int k = 0; k < 400; k++) begin
      if (!busy_o) break;
      step();
    end
    chk(busy_o == 1'b0, "R8", 32'(busy_o), 32'h0);
    chk(dma_req_o == 1'b0, "R7", 32'(dma_req_o), 32'h0);
    repeat (8) step();
    chk(req_starts - base_reqs == exp_reqs, "R7", 32'(req_starts - base_reqs), 32'(exp_reqs));
    chk(exp_rd.size() == 0, "R11", 32'(exp_rd.size()), 32'h0);
    chk(exp_wr.size() == 0, "R6", 32'(exp_wr.size()), 32'h0);
    chk(exp_op.size() == 0, "R2", 32'(exp_op.size()), 32'h0);
  endtask

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R8 watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int b;
    repeat (3) step();
    rst_n = 1;
    step();
    // Reset state
    chk({busy_o, err_o, dma_req_o, op_valid_o, rd_valid_o, bus_oe_o} == 6'b0, "R8",
        {26'd0, busy_o, err_o, dma_req_o, op_valid_o, rd_valid_o, bus_oe_o}, 32'h0);

    // R1/R3: plain opcode bytes are ignored
    host_fetch(16'h9090);
    host_qs(2'b01);
    chk(busy_o == 1'b0, "R1", 32'(busy_o), 32'h0);
    host_qs(2'b11);
    chk(busy_o == 1'b0 && !op_valid_o, "R1", 32'(busy_o), 32'h0);

    // R10: register form
    b = req_starts;
    issue_esc(8'hD8, 8'hC1, 0, 0, 16'h0, 16'h0, 1);
    finish_esc(0, b);

    // R4: one-word load
    b = req_starts;
    issue_esc(8'hDF, 8'h06, 0, 1, 16'h2000, 16'h1234, 1);
    finish_esc(0, b);

    // R5: two-word load
    b = req_starts;
    issue_esc(8'hD9, 8'h06, 0, 2, 16'h1000, 16'hBEEF, 1);
    finish_esc(1, b);

    // R11: five-word load with the read stream held back
    b = req_starts;
    rd_ready_i = 0;
    issue_esc(8'hDB, 8'h2E, 0, 5, 16'h3010, 16'h7777, 1);
    repeat (30) step();
    chk(rd_valid_o == 1'b1, "R11", 32'(rd_valid_o), 32'h1);
    rd_ready_i = 1;
    finish_esc(1, b);

    // R6: two-word store
    b = req_starts;
    issue_esc(8'hD9, 8'h16, 1, 2, 16'h4000, 16'hDEAD, 1);
    finish_esc(1, b);

    // R12: four-word store that waits for its data
    b = req_starts;
    wr_src_en = 0;
    begin
      int a0;
      a0 = ale_count;
      issue_esc(8'hDD, 8'h16, 1, 4, 16'h5100, 16'hDEAD, 1);
      repeat (12) step();
      chk(dma_req_o == 1'b1, "R12", 32'(dma_req_o), 32'h1);
      chk(ale_count == a0, "R12", 32'(ale_count), 32'(a0));
    end
    wr_src_en = 1;
    finish_esc(1, b);

    // One-word store
    b = req_starts;
    issue_esc(8'hDF, 8'h16, 1, 1, 16'h6002, 16'hDEAD, 1);
    finish_esc(1, b);

    // R9: unsupported memory form
    b = req_starts;
    issue_esc(8'hDE, 8'h06, 0, 0, 16'h7000, 16'h5555, 0);
    chk(err_o == 1'b1, "R9", 32'(err_o), 32'h1);
    finish_esc(0, b);
    chk(err_o == 1'b1, "R9", 32'(err_o), 32'h1);
    b = req_starts;
    issue_esc(8'hD8, 8'hC2, 0, 0, 16'h0, 16'h0, 1);
    chk(err_o == 1'b0, "R9", 32'(err_o), 32'h0);
    finish_esc(0, b);

    // R3: flush drops a fetched escape
    host_fetch({8'h06, 8'hD9});
    host_qs(2'b10);
    host_fetch(16'h9090);
    host_qs(2'b01);
    chk(busy_o == 1'b0, "R3", 32'(busy_o), 32'h0);
    host_qs(2'b01);
    chk(busy_o == 1'b0 && !op_valid_o, "R3", 32'(busy_o), 32'h0);

    // R2: opcode held while not accepted
    b = req_starts;
    op_ready_i = 0;
    issue_esc(8'hDC, 8'hE3, 0, 0, 16'h0, 16'h0, 1);
    for (int k = 0; k < 5; k++) begin
      step();
      chk(op_valid_o && op_code_o == 11'h4E3, "R2", {21'd0, op_code_o}, 32'h4E3);
      chk(busy_o == 1'b1, "R8", 32'(busy_o), 32'h1);
    end
    op_ready_i = 1;
    finish_esc(0, b);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule